// File: doc/BRIEF.md
# Serial Receive Path with Trigger-Level Flow Control

This block is the receive half of an asynchronous serial port. It takes the raw receive line and a strobe that pulses sixteen times per bit period. A falling edge on the idle line starts a frame. The start bit is confirmed at its midpoint. Data bits are then taken least significant first, each at its midpoint. The frame may carry a parity bit, and it ends with a stop bit that must be high. The receiver rejects a glitch that looks like a start bit. It also recognises a line held low for a whole frame as a break.

Each character goes into a sixteen-entry first-in first-out store, together with its parity, framing and break flags. A consumer drains the store through a show-ahead read port. A trigger level can be set to 1, 4, 8 or 14 characters. When the fill count reaches it, the block raises a DMA request. With automatic flow control enabled, the block also drops its request-to-send output so the far end pauses until the store is drained below the trigger.

Top module: `uart_rx_fc`

## Requirements
- R1: After reset the store is empty (level 0, empty high, data_ready low), overrun is low, dma_req is low and rts_o is high.
- R2: cfg_len selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first. The stored character is zero-extended to 8 bits.
- R3: cfg_par code 1 selects even parity and code 2 selects odd parity. A parity bit follows the data bits. If it does not match, the entry's perr flag is set. Codes 0 and 3 mean no parity bit, and perr stays low.
- R4: A low level at the first stop-bit sample sets ferr in that character's entry. The data bits are kept, and no extra character results from the low stop bit.
- R5: A start bit that is high again at its midpoint sample loads nothing, and the receiver returns to idle.
- R6: A frame whose start, data, parity and stop samples are all low is stored as one entry with data 0, brk 1 and ferr 1. Nothing more is stored until the line has returned high.
- R7: The store holds 16 entries in arrival order. rd_data and the flags show the oldest entry. A pulse on rd_i removes it, and fifo_level counts the entries.
- R8: A character that completes while the store is full is dropped and sets the sticky overrun flag. stat_rd_i clears that flag.
- R9: cfg_trig codes 0, 1, 2 and 3 select trigger levels 1, 4, 8 and 14. dma_req is high exactly when fifo_level is at or above the trigger level.
- R10: With cfg_autorts low, rts_o stays high. With cfg_autorts high, rts_o is low while fifo_level is at or above the trigger level and high while it is below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| tick_i | input | 1 | One-cycle strobe at sixteen times the bit rate |
| cfg_len | input | 2 | Data bit count code (5 to 8) |
| cfg_par | input | 2 | Parity mode code |
| cfg_trig | input | 2 | Trigger level code |
| cfg_autorts | input | 1 | Enables automatic request-to-send throttling |
| rd_i | input | 1 | Removes the oldest entry |
| stat_rd_i | input | 1 | Status read; clears overrun |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error flag of oldest entry |
| rd_ferr | output | 1 | Framing error flag of oldest entry |
| rd_brk | output | 1 | Break flag of oldest entry |
| fifo_level | output | 5 | Number of stored entries |
| fifo_empty | output | 1 | Store is empty |
| fifo_full | output | 1 | Store is full |
| data_ready | output | 1 | At least one entry is available |
| overrun | output | 1 | Sticky lost-character flag |
| dma_req | output | 1 | Fill level has reached the trigger |
| rts_o | output | 1 | Request-to-send, high lets the sender continue |

## Verification
The bench sends randomly chosen characters under every length and parity setting, with a random share of them carrying a flipped parity bit. This separates bit ordering and masking faults from faults in the parity sense. Directed frames follow: a low stop bit, a short low glitch and a long low hold. They tell a framing error apart from a false start and from a break, and the bench checks that a lingering low line does not add entries. A fill to capacity and one character past it, followed by a drain at a fixed trigger, shows the dropped character, the clearing of the overrun flag, and the exact level at which the DMA request and request-to-send change.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    function automatic logic [4:0] trig_count(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    output logic       push_o,
    output rx_char_t   char_o
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_e              state;
    logic [CW-1:0]          tcnt;
    logic [2:0]             bit_idx;
    logic [7:0]             shreg;
    logic                   all_zero;
    logic                   perr_q;
    par_mode_e              pmode;
    logic                   par_on;

    assign rx_s   = sync_q[SYNC_STAGES-1];
    assign pmode  = par_mode_e'(cfg_par);
    assign par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            tcnt     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            all_zero <= 1'b0;
            perr_q   <= 1'b0;
            push_o   <= 1'b0;
            char_o   <= '0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    S_IDLE: begin
                        if (!rx_s) begin
                            state <= S_START;
                            tcnt  <= '0;
                        end
                    end
                    S_START: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == MID) begin
                            tcnt <= '0;
                            if (rx_s) begin
                                state <= S_IDLE;
                            end else begin
                                state    <= S_DATA;
                                bit_idx  <= '0;
                                shreg    <= '0;
                                all_zero <= 1'b1;
                                perr_q   <= 1'b0;
                            end
                        end
                    end
                    S_DATA: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == LAST) begin
                            shreg[bit_idx] <= rx_s;
                            all_zero       <= all_zero & ~rx_s;
                            if (bit_idx == last_bit_idx(cfg_len))
                                state <= par_on ? S_PAR : S_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    S_PAR: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == LAST) begin
                            perr_q   <= (^shreg) ^ rx_s ^ (pmode == PAR_ODD);
                            all_zero <= all_zero & ~rx_s;
                            state    <= S_STOP;
                        end
                    end
                    S_STOP: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == LAST) begin
                            push_o <= 1'b1;
                            if (all_zero && !rx_s) begin
                                char_o <= '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: 8'h00};
                                state  <= S_BRKWAIT;
                            end else begin
                                char_o <= '{brk: 1'b0, ferr: ~rx_s, perr: perr_q, data: shreg};
                                state  <= S_IDLE;
                            end
                        end
                    end
                    S_BRKWAIT: begin
                        if (rx_s) state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  rx_char_t      din,
    input  logic          pop_i,
    input  logic          stat_clr_i,
    output rx_char_t      dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          overrun
);
    rx_char_t       mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic           do_pop, do_push, drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop_i && !empty;
    assign do_push = push_i && (!full || do_pop);
    assign drop    = push_i && !do_push;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (drop)            overrun <= 1'b1;
            else if (stat_clr_i) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_flow.sv
module rx_flow
    import uart_rx_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic [LW-1:0] level,
    input  logic [1:0]    cfg_trig,
    input  logic          cfg_autorts,
    output logic          dma_req,
    output logic          rts_o
);
    logic [LW-1:0] thresh;
    logic          at_trig;

    assign thresh  = LW'(trig_count(cfg_trig));
    assign at_trig = (level >= thresh);
    assign dma_req = at_trig;
    assign rts_o   = !cfg_autorts || !at_trig;
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
    import uart_rx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int OVERSAMPLE = 16,
    localparam int LVL_W     = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             tick_i,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_par,
    input  logic [1:0]       cfg_trig,
    input  logic             cfg_autorts,
    input  logic             rd_i,
    input  logic             stat_rd_i,
    output logic [7:0]       rd_data,
    output logic             rd_perr,
    output logic             rd_ferr,
    output logic             rd_brk,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             data_ready,
    output logic             overrun,
    output logic             dma_req,
    output logic             rts_o
);
    logic     rx_push;
    rx_char_t rx_char;
    rx_char_t head;

    rx_deframer #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(2)) u_deframer (
        .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
        .cfg_len(cfg_len), .cfg_par(cfg_par),
        .push_o(rx_push), .char_o(rx_char)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(rx_push), .din(rx_char),
        .pop_i(rd_i), .stat_clr_i(stat_rd_i), .dout(head),
        .level(fifo_level), .full(fifo_full), .empty(fifo_empty),
        .overrun(overrun)
    );

    rx_flow #(.LW(LVL_W)) u_flow (
        .level(fifo_level), .cfg_trig(cfg_trig), .cfg_autorts(cfg_autorts),
        .dma_req(dma_req), .rts_o(rts_o)
    );

    assign rd_data    = head.data;
    assign rd_perr    = head.perr;
    assign rd_ferr    = head.ferr;
    assign rd_brk     = head.brk;
    assign data_ready = !fifo_empty;
endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_i,
    input logic          stat_rd_i,
    input logic          cfg_autorts,
    input logic          push,
    input rx_char_t      push_char,
    input logic [LW-1:0] fifo_level,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          overrun,
    input logic          dma_req,
    input logic          rts_o
);
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    assert_pop_step_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !fifo_empty && !push) |=> (fifo_level == LW'($past(fifo_level) - 1'b1)));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
        (push && fifo_full && !rd_i) |=> overrun);

    assert_overrun_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && !(push && fifo_full && !rd_i)) |=> !overrun);

    assert_break_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (push && push_char.brk) |-> (push_char.data == 8'h00 && push_char.ferr && !push_char.perr));

    assert_full_requests_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> dma_req);

    assert_full_throttles_R10: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && cfg_autorts) |-> !rts_o);
endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .rd_i(rd_i), .stat_rd_i(stat_rd_i),
    .cfg_autorts(cfg_autorts), .push(rx_push), .push_char(rx_char),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .overrun(overrun), .dma_req(dma_req), .rts_o(rts_o)
);

// File: tb/uart_rx_fc_test.sv
module uart_rx_fc_test;
    localparam int BIT = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_i = 1'b1;
    logic tick_i = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_trig = 2'd0;
    logic cfg_autorts = 1'b0;
    logic rd_i = 1'b0, stat_rd_i = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, fifo_empty, fifo_full, data_ready, overrun, dma_req, rts_o;
    logic [4:0] fifo_level;

    int errors = 0;
    int checks = 0;
    int tdiv = 0;
    bit done = 1'b0;
    logic [7:0] sent [16];

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_i <= (tdiv == 3);
        tdiv   <= (tdiv + 1) % 4;
    end

    uart_rx_fc uut (
        .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_trig(cfg_trig),
        .cfg_autorts(cfg_autorts), .rd_i(rd_i), .stat_rd_i(stat_rd_i),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .data_ready(data_ready), .overrun(overrun), .dma_req(dma_req), .rts_o(rts_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int trig_of(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] masked(input logic [7:0] d, input int nb);
        return d & 8'((1 << nb) - 1);
    endfunction

    function automatic bit par_bit(input logic [7:0] d, input int nb, input logic [1:0] pm);
        return (^masked(d, nb)) ^ (pm == 2'd2);
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb = 5 + int'(cfg_len);
        rx_i = 1'b0; hold(BIT);
        for (int i = 0; i < nb; i++) begin
            rx_i = d[i]; hold(BIT);
        end
        if (cfg_par == 2'd1 || cfg_par == 2'd2) begin
            rx_i = par_bit(d, nb, cfg_par) ^ bad_par; hold(BIT);
        end
        rx_i = !bad_stop; hold(BIT);
        rx_i = 1'b1; hold(BIT);
    endtask

    task automatic pop;
        rd_i = 1'b1; hold(1); rd_i = 1'b0; hold(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        hold(5);
        rst = 1'b0;
        hold(2);
        // R1 reset state
        chk("R1", "level", int'(fifo_level), 0);
        chk("R1", "empty", int'(fifo_empty), 1);
        chk("R1", "data_ready", int'(data_ready), 0);
        chk("R1", "overrun", int'(overrun), 0);
        chk("R1", "dma_req", int'(dma_req), 0);
        chk("R1", "rts", int'(rts_o), 1);
        hold(BIT);

        // R2 directed 8-bit, no parity
        cfg_len = 2'd3; cfg_par = 2'd0;
        send_frame(8'hA5, 1'b0, 1'b0);
        chk("R2", "level 8N", int'(fifo_level), 1);
        chk("R2", "data 8N", int'(rd_data), 8'hA5);
        chk("R3", "perr none", int'(rd_perr), 0);
        pop();

        // R3 directed 5-bit even parity, correct then flipped
        cfg_len = 2'd0; cfg_par = 2'd1;
        send_frame(8'h16, 1'b0, 1'b0);
        chk("R2", "data 5E", int'(rd_data), 8'h16);
        chk("R3", "perr even ok", int'(rd_perr), 0);
        pop();
        send_frame(8'h16, 1'b1, 1'b0);
        chk("R3", "perr even bad", int'(rd_perr), 1);
        pop();

        // R2/R3 random formats and data
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d = 8'($urandom);
            bit bp = ($urandom % 4) == 0;
            int nb;
            cfg_len = 2'($urandom);
            cfg_par = 2'($urandom);
            nb = 5 + int'(cfg_len);
            send_frame(d, bp, 1'b0);
            chk("R2", "rand level", int'(fifo_level), 1);
            chk("R2", "rand data", int'(rd_data), int'(masked(d, nb)));
            chk("R3", "rand perr", int'(rd_perr), int'(bp && (cfg_par == 2'd1 || cfg_par == 2'd2)));
            chk("R4", "rand ferr", int'(rd_ferr), 0);
            pop();
        end

        // R4 framing error
        cfg_len = 2'd3; cfg_par = 2'd0;
        send_frame(8'h3C, 1'b0, 1'b1);
        chk("R4", "level", int'(fifo_level), 1);
        chk("R4", "data", int'(rd_data), 8'h3C);
        chk("R4", "ferr", int'(rd_ferr), 1);
        chk("R4", "brk", int'(rd_brk), 0);
        pop();

        // R5 false start
        rx_i = 1'b0; hold(16); rx_i = 1'b1; hold(20 * BIT);
        chk("R5", "false start level", int'(fifo_level), 0);

        // R6 break
        rx_i = 1'b0; hold(12 * BIT);
        chk("R6", "break level", int'(fifo_level), 1);
        chk("R6", "break brk", int'(rd_brk), 1);
        chk("R6", "break data", int'(rd_data), 0);
        chk("R6", "break ferr", int'(rd_ferr), 1);
        hold(20 * BIT);
        chk("R6", "held low level", int'(fifo_level), 1);
        rx_i = 1'b1; hold(2 * BIT);
        pop();
        send_frame(8'h55, 1'b0, 1'b0);
        chk("R6", "after break data", int'(rd_data), 8'h55);
        chk("R6", "after break brk", int'(rd_brk), 0);
        pop();

        // R9/R10 trigger 4 with auto RTS
        cfg_autorts = 1'b1; cfg_trig = 2'd1;
        for (int n = 0; n < 3; n++) send_frame(8'(n + 1), 1'b0, 1'b0);
        chk("R9", "below trig dma", int'(dma_req), 0);
        chk("R10", "below trig rts", int'(rts_o), 1);
        send_frame(8'h04, 1'b0, 1'b0);
        chk("R9", "at trig dma", int'(dma_req), 1);
        chk("R10", "at trig rts", int'(rts_o), 0);
        pop();
        chk("R10", "reassert rts", int'(rts_o), 1);
        chk("R9", "drop dma", int'(dma_req), 0);
        for (int n = 0; n < 3; n++) pop();
        chk("R7", "drained", int'(fifo_empty), 1);

        // R7/R8/R9 trigger 14, fill and overflow
        cfg_trig = 2'd3;
        for (int n = 0; n < 16; n++) begin
            sent[n] = 8'($urandom);
            send_frame(sent[n], 1'b0, 1'b0);
            if (n == 12) begin
                chk("R9", "13 dma", int'(dma_req), 0);
                chk("R10", "13 rts", int'(rts_o), 1);
            end
            if (n == 13) begin
                chk("R9", "14 dma", int'(dma_req), 1);
                chk("R10", "14 rts", int'(rts_o), 0);
            end
        end
        chk("R7", "full", int'(fifo_full), 1);
        chk("R8", "no overrun yet", int'(overrun), 0);
        send_frame(8'hEE, 1'b0, 1'b0);
        chk("R8", "overrun set", int'(overrun), 1);
        chk("R8", "level stays", int'(fifo_level), 16);
        cfg_autorts = 1'b0; hold(1);
        chk("R10", "rts when disabled", int'(rts_o), 1);
        cfg_autorts = 1'b1;
        stat_rd_i = 1'b1; hold(1); stat_rd_i = 1'b0; hold(1);
        chk("R8", "overrun cleared", int'(overrun), 0);

        // drain with trigger 8
        cfg_trig = 2'd2;
        for (int n = 0; n < 16; n++) begin
            hold(1);
            chk("R7", "order", int'(rd_data), int'(sent[n]));
            chk("R9", "drain dma", int'(dma_req), int'((16 - n) >= trig_of(cfg_trig)));
            chk("R10", "drain rts", int'(rts_o), int'((16 - n) < trig_of(cfg_trig)));
            pop();
        end
        chk("R8", "dropped char absent", int'(fifo_empty), 1);

        // R9 trigger 1
        cfg_trig = 2'd0; hold(1);
        chk("R9", "trig1 empty", int'(dma_req), 0);
        send_frame(8'h81, 1'b0, 1'b0);
        chk("R9", "trig1 one", int'(dma_req), 1);
        pop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule